// File: doc/BRIEF.md
# Reset Source Capture Unit

This unit merges three reset requests into one internal chip reset: a power-on strobe, a level from the external reset pin (already synchronized), and a timeout strobe from the watchdog timer. A watchdog timeout becomes a reset pulse exactly one clock wide. Whichever source fires, the internal reset is held for a fixed start-up delay after the last active source goes quiet. The delay length is a parameter.

Software learns what caused the last reset from an 8-bit status byte behind a single read/write location. Bit 0 records a power-on and bit 1 records an external pin reset. The watchdog leaves both flags alone, so a reset with neither flag set after software cleared both points to the watchdog. The byte is never cleared by the internal reset it describes. Only a power-on changes it, apart from the flag rules below.

Top module: `rst_cause_unit`

## Requirements
- R1: A rising edge on `wdt_timeout_i` produces `wdt_pulse_o` high for exactly one cycle, in the cycle after the edge. Holding the timeout input high produces no second pulse.
- R2: `sys_rst_o` goes high on the clock edge that samples any active source (power-on, external pin, or watchdog pulse). It falls on the edge `DLY_CYCLES` edges after the last edge that sampled an active source.
- R3: Status bit 0 (power-on flag) is set by a power-on. External and watchdog resets leave it unchanged.
- R4: Status bit 1 (external flag) is set by an external reset and left unchanged by a watchdog reset. After a power-on its value is undefined.
- R5: A register write with a 0 in bit 0 or bit 1 clears the matching flag on the next edge.
- R6: A register write with a 1 in a flag bit leaves that flag unchanged. No write ever sets a flag.
- R7: Status bits 7 to 2 always read 0, whatever is written.
- R8: The internal reset (`sys_rst_o`) never clears the status byte. Flags set before an external or watchdog reset are still readable during and after it.
- R9: When a reset event and a write of 0 hit the same flag in one cycle, the flag ends up set.
- R10: While the external pin is held, the delay does not run. The delay starts counting only once the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on request, active high, sampled on clk |
| ext_rst_i | input | 1 | External reset level, active high, synchronized |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe or level |
| reg_wr_i | input | 1 | Write strobe for the status byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Status byte: bit 1 external flag, bit 0 power-on flag |
| wdt_pulse_o | output | 1 | One-cycle watchdog reset pulse |
| sys_rst_o | output | 1 | Stretched internal reset, active high |

## Verification
The assertions check these rules on every cycle:
- The watchdog pulse never lasts two cycles.
- Any active source raises the internal reset on the next edge.
- The internal reset cannot drop before the counter reaches its terminal value.
- The flags are set after their events.
- A watchdog pulse alone leaves the status byte stable.

Some behaviours only the bench scenarios can show, by comparison with a behavioural model:
- The exact length of the stretch after a long external pin hold.
- Which cycle the flags clear in.
- Event-over-clear priority in the same cycle.
- That writing ones changes nothing.
- That a long-held timeout gives a single pulse.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
    // Bit positions software decodes in the status byte
    localparam int POR_BIT = 0;
    localparam int EXT_BIT = 1;
    localparam int REG_W   = 8;

    typedef struct packed {
        logic ext_flag;
        logic por_flag;
    } rcu_flags_t;
endpackage

// File: rtl/rcu_wdt_pulse.sv
module rcu_wdt_pulse (
    input  logic clk,
    input  logic por_i,
    input  logic timeout_i,
    output logic pulse_o
);
    typedef struct packed {
        logic seen;
        logic pulse;
    } wp_state_t;

    wp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (por_i) begin
            st_d.seen  = 1'b0;
            st_d.pulse = 1'b0;
        end else begin
            st_d.pulse = timeout_i & ~st_q.seen;
            st_d.seen  = timeout_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (por_i)
        st_q.pulse |=> !st_q.pulse); // R1
    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (por_i)
        $rose(timeout_i) |=> pulse_o); // R1
endmodule

// File: rtl/rcu_delay.sv
module rcu_delay #(
    parameter int CNT_W      = 6,
    parameter int DLY_CYCLES = 24
) (
    input  logic clk,
    input  logic por_i,
    input  logic src_active_i,
    output logic rst_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DLY_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (src_active_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == LAST_CNT) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rst_o = st_q.busy;

    AST_SRC_RAISES_RST: assert property (@(posedge clk)
        src_active_i |=> rst_o); // R2
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (por_i)
        (st_q.busy && !src_active_i && st_q.cnt != LAST_CNT) |=> rst_o); // R10
endmodule

// File: rtl/rcu_status.sv
module rcu_status
    import rcu_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic             ext_rst_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o
);
    rcu_flags_t fl_d, fl_q;
    logic       unused_wdata;

    assign unused_wdata = ^wdata_i[REG_W-1:2];

    always_comb begin
        fl_d = fl_q;
        // software clear first, so a same-cycle event wins below
        if (wr_i && !wdata_i[POR_BIT]) fl_d.por_flag = 1'b0;
        if (wr_i && !wdata_i[EXT_BIT]) fl_d.ext_flag = 1'b0;
        if (por_i)     fl_d.por_flag = 1'b1;
        if (ext_rst_i) fl_d.ext_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        fl_q <= fl_d;
    end

    always_comb begin
        rdata_o          = '0;
        rdata_o[POR_BIT] = fl_q.por_flag;
        rdata_o[EXT_BIT] = fl_q.ext_flag;
    end

    AST_POR_SETS_FLAG: assert property (@(posedge clk)
        por_i |=> rdata_o[POR_BIT]); // R3
    AST_EXT_SETS_FLAG: assert property (@(posedge clk)
        ext_rst_i |=> rdata_o[EXT_BIT]); // R4
    AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (por_i)
        (wr_i && !ext_rst_i && !rdata_o[EXT_BIT]) |=> !rdata_o[EXT_BIT]); // R6
    AST_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (por_i)
        (wr_i && !wdata_i[POR_BIT]) |=> !rdata_o[POR_BIT]); // R5
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
    import rcu_pkg::*;
#(
    parameter int CNT_W      = 6,
    parameter int DLY_CYCLES = 24
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             ext_rst_i,
    input  logic             wdt_timeout_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             wdt_pulse_o,
    output logic             sys_rst_o
);
    logic wdt_pulse;
    logic src_active;

    rcu_wdt_pulse u_wdt (
        .clk       (clk),
        .por_i     (por_i),
        .timeout_i (wdt_timeout_i),
        .pulse_o   (wdt_pulse)
    );

    assign src_active = por_i | ext_rst_i | wdt_pulse;

    rcu_delay #(
        .CNT_W      (CNT_W),
        .DLY_CYCLES (DLY_CYCLES)
    ) u_dly (
        .clk          (clk),
        .por_i        (por_i),
        .src_active_i (src_active),
        .rst_o        (sys_rst_o)
    );

    rcu_status u_stat (
        .clk       (clk),
        .por_i     (por_i),
        .ext_rst_i (ext_rst_i),
        .wr_i      (reg_wr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o)
    );

    assign wdt_pulse_o = wdt_pulse;

    AST_WDT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (por_i)
        (wdt_pulse && !reg_wr_i && !ext_rst_i) |=> $stable(reg_rdata_o)); // R4
endmodule

// File: tb/rst_cause_unit_tb.sv
module rst_cause_unit_tb;
    localparam int DLY = 24;

    logic       clk = 1'b0;
    logic       por = 1'b0, ext = 1'b0, wdt = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pulse, srst;

    int compared   = 0;
    int mismatched = 0;

    // behavioural reference state
    bit m_valid = 0, m_pulse = 0, m_prev_to = 0, m_por = 0, m_ext = 0, m_ext_known = 0;
    int m_quiet = DLY;

    always #10 clk = ~clk; // 50 MHz

    rst_cause_unit #(.CNT_W(6), .DLY_CYCLES(DLY)) u_dut (
        .clk(clk), .por_i(por), .ext_rst_i(ext), .wdt_timeout_i(wdt),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .wdt_pulse_o(pulse), .sys_rst_o(srst)
    );

    always @(posedge clk) begin
        bit src;
        src = por || ext || m_pulse;
        // R2 / R10: count quiet cycles since the last active source
        if (src) m_quiet = 0;
        else if (m_quiet < DLY) m_quiet = m_quiet + 1;
        // R1
        if (por) begin m_pulse = 0; m_prev_to = 0; end
        else begin m_pulse = wdt && !m_prev_to; m_prev_to = wdt; end
        // R3 R4 R5 R6 R9
        if (wr && !wdata[0]) m_por = 0;
        if (wr && !wdata[1]) begin m_ext = 0; m_ext_known = 1; end
        if (por) begin m_por = 1; m_ext_known = 0; end
        if (ext) begin m_ext = 1; m_ext_known = 1; end
        if (por) m_valid = 1;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid) begin
            chk("R1 wdt_pulse_o", {7'd0, pulse}, {7'd0, m_pulse});
            chk("R2 sys_rst_o", {7'd0, srst}, {7'd0, (m_quiet < DLY)});
            chk("R3 por flag", {7'd0, rdata[0]}, {7'd0, m_por});
            if (m_ext_known) chk("R4 ext flag", {7'd0, rdata[1]}, {7'd0, m_ext});
            chk("R7 reserved bits", {2'b0, rdata[7:2]}, 8'h00);
        end
    end

    task automatic step(input bit p, input bit e, input bit w, input bit wv, input logic [7:0] d);
        @(negedge clk);
        por = p; ext = e; wdt = w; wr = wv; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        // R3 power-on, R2 stretch
        step(1, 0, 0, 0, 8'h00);
        step(1, 0, 0, 0, 8'h00);
        idle(DLY + 4);
        // R8 R3 R4: external reset keeps power-on flag; R10 held pin
        for (int i = 0; i < 7; i++) step(0, 1, 0, 0, 8'h00);
        idle(DLY + 4);
        // R5 R6: clear external flag only, then power-on flag only
        step(0, 0, 0, 1, 8'hFD);
        step(0, 0, 0, 1, 8'hFE);
        idle(2);
        // R6 R7: writing ones sets nothing, reserved stay zero
        step(0, 0, 0, 1, 8'hFF);
        idle(2);
        // R9: event beats same-cycle clear
        step(0, 1, 0, 1, 8'h00);
        idle(DLY + 3);
        step(1, 0, 0, 1, 8'h00);
        idle(DLY + 3);
        // R1 R4 R8: long timeout gives one pulse, flags stay
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 8'h00);
        idle(DLY + 4);
        // R1: back-to-back short timeouts, second during stretch
        step(0, 0, 1, 0, 8'h00); step(0, 0, 0, 0, 8'h00); step(0, 0, 1, 0, 8'h00);
        idle(DLY + 4);
        // mixed random traffic covering all requirements
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 99);
            step(r < 2, (r >= 2 && r < 6), $urandom_range(0, 5) == 0,
                 $urandom_range(0, 3) == 0, 8'($urandom()));
        end
        idle(DLY + 4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule